// File: doc/BRIEF.md
# Modem Status View and Extended Control Register

This block is the register slice of a 16550-style serial port that shares one address between two views. A read returns the modem input status: four level bits and four change flags. A write sets four extended feature controls: transmitter off, receiver off, 9-bit multidrop framing and the fast infrared pulse mode. A write takes effect only while the enhanced-feature enable from the feature register is set. Otherwise the write is dropped.

The four active-low modem pins pass through a two-flop synchronizer and are then inverted. In loopback the status bits come from the modem control outputs, so software can test the path without the pins. The block also drives a transmit permission signal for hardware flow control. While auto flow control is on, the clear-to-send status is copied to that signal only at points where the transmitter is idle or about to start a character. A character that has already begun is never cut short.

Top module: `modem_stat_xctl`

## Requirements
- R1: Outside loopback, read data bits 4, 5, 6 and 7 are the inverse of `cts_n`, `dsr_n`, `ri_n` and `cd_n` in that order. Each pin passes through two synchronizing flops first.
- R2: With `loopback` high, read bit 4 equals `mcr_rts`, bit 5 equals `mcr_dtr`, bit 6 equals `mcr_out1` and bit 7 equals `mcr_out2`. The pins have no effect on these bits.
- R3: Read bits 0, 1 and 3 set when the status bit for CTS, DSR or CD (bits 4, 5 and 7) changes in either direction. Read bit 2 sets only when status bit 6 (RI) falls from 1 to 0.
- R4: A read returns the change flags as they stand and clears them on the following clock edge.
- R5: A write with `efr_feat` high loads `wdata[4]` into `tx_disable`, `wdata[5]` into `rx_disable`, `wdata[6]` into `nine_bit` and `wdata[7]` into `fast_ir`. `wdata[3:0]` has no effect.
- R6: A write with `efr_feat` low leaves all four control outputs unchanged.
- R7: After reset all control outputs are 0, all change flags are 0, and `tx_go` is 1.
- R8: On a clock edge where `tx_boundary` is high, `tx_go` loads 0 if `efr_acts` is high and status bit 4 is 0 (CTS pin high). In every other case it loads 1.
- R9: `tx_go` holds its value on every edge where `tx_boundary` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe for this address |
| wr_en | input | 1 | Write strobe for this address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data: status in bits 7..4, change flags in bits 3..0 |
| efr_feat | input | 1 | Enhanced-feature enable; gates control writes |
| efr_acts | input | 1 | Auto clear-to-send flow control enable |
| loopback | input | 1 | Loopback mode select |
| mcr_rts | input | 1 | Modem control RTS bit |
| mcr_dtr | input | 1 | Modem control DTR bit |
| mcr_out1 | input | 1 | Modem control bit 2 |
| mcr_out2 | input | 1 | Modem control bit 3 |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring-indicator pin, active low |
| cd_n | input | 1 | Carrier-detect pin, active low |
| tx_boundary | input | 1 | Transmitter is idle or about to start a character |
| tx_go | output | 1 | Transmit permission |
| tx_disable | output | 1 | Transmitter disabled |
| rx_disable | output | 1 | Receiver disabled |
| nine_bit | output | 1 | 9-bit multidrop mode |
| fast_ir | output | 1 | Fast infrared mode |

## Verification
The assertions check the control write rules on every cycle: a gated write loads exactly the upper data nibble, a write with the enable low changes nothing, and no control changes without a write. They also check that the transmit permission moves only on a boundary and is always granted when auto flow control is off. The status inversion, the loopback mapping, the choice of edge for each change flag and the clear-on-read behaviour depend on pin timing through the synchronizer. Only the bench scenarios show these, by comparing each read against the value computed for that pin or loopback pattern.

// File: rtl/modem_stat_xctl.sv
module modem_stat_xctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       efr_feat,
  input  logic       efr_acts,
  input  logic       loopback,
  input  logic       mcr_rts,
  input  logic       mcr_dtr,
  input  logic       mcr_out1,
  input  logic       mcr_out2,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       cd_n,
  input  logic       tx_boundary,
  output logic       tx_go,
  output logic       tx_disable,
  output logic       rx_disable,
  output logic       nine_bit,
  output logic       fast_ir
);
  logic [3:0] pin_s1, pin_s2;
  logic [3:0] stat, stat_q, delta, chg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_s1 <= 4'hF;
      pin_s2 <= 4'hF;
    end else begin
      pin_s1 <= {cd_n, ri_n, dsr_n, cts_n};
      pin_s2 <= pin_s1;
    end

  assign stat = loopback ? {mcr_out2, mcr_out1, mcr_dtr, mcr_rts} : ~pin_s2;

  assign chg[0] = stat[0] ^ stat_q[0];
  assign chg[1] = stat[1] ^ stat_q[1];
  assign chg[2] = stat_q[2] & ~stat[2];
  assign chg[3] = stat[3] ^ stat_q[3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat_q <= '0;
      delta  <= '0;
    end else begin
      stat_q <= stat;
      delta  <= (rd_en ? 4'h0 : delta) | chg;
    end

  assign rdata = {stat, delta};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      {fast_ir, nine_bit, rx_disable, tx_disable} <= '0;
    else if (wr_en && efr_feat)
      {fast_ir, nine_bit, rx_disable, tx_disable} <= wdata[7:4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      tx_go <= 1'b1;
    else if (tx_boundary)
      tx_go <= !efr_acts || stat[0];
endmodule

module modem_stat_xctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       efr_feat,
  input logic       efr_acts,
  input logic [7:0] wdata,
  input logic       tx_boundary,
  input logic       tx_go,
  input logic [3:0] ctl
);
  assert_ctl_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && efr_feat |=> ctl == $past(wdata[7:4]));
  assert_ctl_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !efr_feat |=> $stable(ctl));
  assert_ctl_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl));
  assert_go_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_boundary |=> $stable(tx_go));
  assert_go_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_boundary && !efr_acts |=> tx_go);
endmodule

bind modem_stat_xctl modem_stat_xctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .efr_feat(efr_feat),
  .efr_acts(efr_acts), .wdata(wdata), .tx_boundary(tx_boundary),
  .tx_go(tx_go), .ctl({fast_ir, nine_bit, rx_disable, tx_disable})
);

// File: tb/tb_modem_stat_xctl.sv
module tb_modem_stat_xctl;
  logic clk = 0, rst_n = 0;
  logic rd_en = 0, wr_en = 0, efr_feat = 0, efr_acts = 0, loopback = 0;
  logic mcr_rts = 0, mcr_dtr = 0, mcr_out1 = 0, mcr_out2 = 0;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, cd_n = 1, tx_boundary = 0;
  logic [7:0] wdata = 0, rdata;
  logic tx_go, tx_disable, rx_disable, nine_bit, fast_ir;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  modem_stat_xctl dut (.*);

  always @(negedge clk)
    if (rd_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s rdata=%h expected=%h", t, rdata, e);
      end
    end

  task automatic rd(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1 rd_en = 1;
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1 wr_en = 1; wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic chk(input logic [4:0] act, input logic [4:0] e, input string t);
    @(negedge clk);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", t, act, e);
    end
  endtask

  task automatic boundary();
    @(posedge clk); #1 tx_boundary = 1;
    @(posedge clk); #1 tx_boundary = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk({tx_go, fast_ir, nine_bit, rx_disable, tx_disable}, 5'b10000, "R7 reset outputs");
    rd(8'h00, "R7 reset read");

    cts_n = 0; settle();
    rd(8'h11, "R1 R3 cts assert");
    rd(8'h10, "R4 flag cleared");

    dsr_n = 0; cd_n = 0; settle();
    rd(8'hBA, "R1 R3 dsr cd assert");
    rd(8'hB0, "R4 flags cleared");

    ri_n = 0; settle();
    rd(8'hF0, "R3 ri leading edge no flag");
    ri_n = 1; settle();
    rd(8'hB4, "R3 ri trailing edge flag");
    rd(8'hB0, "R4 ri flag cleared");

    mcr_rts = 1; mcr_out1 = 1; loopback = 1; settle();
    rd(8'h5A, "R2 R3 loopback entry");
    cts_n = 1; dsr_n = 0; cd_n = 1; settle();
    rd(8'h50, "R2 pins ignored in loopback");
    cd_n = 0; loopback = 0; settle();
    rd(8'hAF, "R1 R3 loopback exit");
    rd(8'hA0, "R4 cleared after exit");

    efr_feat = 0; wr(8'hF0);
    chk({tx_go, fast_ir, nine_bit, rx_disable, tx_disable}, 5'b10000, "R6 gated write");
    efr_feat = 1; wr(8'hA5);
    chk({tx_go, fast_ir, nine_bit, rx_disable, tx_disable}, 5'b11010, "R5 write A5");
    wr(8'h5F);
    chk({tx_go, fast_ir, nine_bit, rx_disable, tx_disable}, 5'b10101, "R5 write 5F low nibble ignored");
    efr_feat = 0; wr(8'h00);
    chk({tx_go, fast_ir, nine_bit, rx_disable, tx_disable}, 5'b10101, "R6 gated write keeps");

    efr_acts = 1; settle();
    chk({4'b0, tx_go}, 5'b00001, "R9 no boundary hold open");
    boundary();
    chk({4'b0, tx_go}, 5'b00000, "R8 cts high stops at boundary");
    cts_n = 0; settle();
    chk({4'b0, tx_go}, 5'b00000, "R9 hold closed without boundary");
    boundary();
    chk({4'b0, tx_go}, 5'b00001, "R8 cts low resumes");
    cts_n = 1; efr_acts = 0; settle(); boundary();
    chk({4'b0, tx_go}, 5'b00001, "R8 flow control off keeps open");

    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule